// File: doc/BRIEF.md
# Frequency Counter Timebase Sequencer

This block turns a 1 MHz reference clock into the three control signals that run a gated frequency counter. A gate level marks the window in which input edges are counted. A one-cycle clear pulse zeroes the counters just before each window. A one-cycle transfer strobe copies a finished count into the display latches. A cascade of divide-by-ten stages sets the window length. A range input picks the third stage's period (1 ms, for the high range) or the last stage's period (1 s, for the low range).

The gate is open for one timebase period and shut for the next. The clear pulse sits in the last cycle of the shut half. Transfers follow their own slower cadence, one every 200 fast periods (200 ms). A transfer is dropped whenever the gate is open or a clear is being issued, so the display only ever receives a completed count. A change of range restarts the whole sequence with a forced clear.

The sequencer has three states:
- `SEQ_PRIME`: gate shut, no window has completed since reset or the last restart.
- `SEQ_OPEN`: counting window.
- `SEQ_SHUT`: gate shut after a completed window; transfers are allowed here.

Its transitions, each taken on the selected period tick, are:
- PRIME to OPEN (issues a clear).
- OPEN to SHUT.
- SHUT to OPEN (issues a clear).

A range change sends any state back to PRIME.

Top module: `fc_timebase_seq`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the cycle after it is sampled, gate, clear and transfer are all low. All dividers restart from zero in state PRIME.
- R2: In the fast range (range input 0) the gate is high for exactly T = STAGE_DIV^FAST_TAP cycles and low for T cycles. Counting the first output sample after reset release as cycle 0, the gate is high at cycle j exactly when floor(j/T) is odd.
- R3: In the slow range (range input 1) the same pattern holds with T = STAGE_DIV^SLOW_TAP.
- R4: Clear is one cycle wide and is high only while the gate is low. It is high exactly at the cycles j where j+1 is a multiple of T and (j+1)/T is odd, so the gate rises in the following cycle.
- R5: Transfer candidates occur every XFER_MULT fast periods, at cycles j that are multiples of XFER_MULT·STAGE_DIV^FAST_TAP. Each strobe that survives is one cycle wide.
- R6: A transfer is never high together with the gate or with clear. A blocked candidate is dropped, not delayed.
- R7: In the fast range (XFER_MULT even), a transfer fires at every candidate j ≥ 2T. This gives one display update per XFER_MULT/2 gate cycles, each landing in a shut half.
- R8: In the slow range, a transfer fires at every candidate that falls in a shut half after the first completed window. Several transfers can occur in one shut half with no clear between them.
- R9: When the range input differs from its value on the previous cycle, the next output sample shows clear high with gate and transfer low. The timing of R2 to R4 then restarts from cycle 0 with the new period.
- R10: No transfer fires before the first window since reset or the last range change has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| range_slow_i | input | 1 | 0 selects the short (fast-range) window, 1 the long (slow-range) window |
| gate_o | output | 1 | Count window, high while counting is enabled |
| clear_o | output | 1 | One-cycle counter clear strobe |
| xfer_o | output | 1 | One-cycle display transfer strobe |

## Verification
The bench builds the block with divide-by-two stages, the fast tap at stage 2 (4-cycle window), the slow tap at stage 5 (32-cycle window) and a transfer every 4 fast periods. These values bring many gate cycles and transfers within a few hundred clocks. They also make the transfer cadence shorter than a slow shut half, so two transfers land between the same pair of clears, as in the full-size slow range. Range changes are applied both during a shut half and during an open window, to exercise the restart and the suppression of a transfer until the next full window has completed.

// File: rtl/fc_tb_pkg.sv
package fc_tb_pkg;

    typedef enum logic [1:0] {
        SEQ_PRIME = 2'd0,
        SEQ_OPEN  = 2'd1,
        SEQ_SHUT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/fc_decade_stage.sv
module fc_decade_stage #(
    parameter int RATIO = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic step_i,
    output logic wrap_o
);
    localparam int W = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [W-1:0] LAST = W'(RATIO - 1);

    logic [W-1:0] cnt;

    assign wrap_o = step_i && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (step_i) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fc_xfer_pacer.sv
module fc_xfer_pacer #(
    parameter int MULT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic fast_tick_i,
    output logic xfer_tick_o
);
    localparam int W = (MULT > 2) ? $clog2(MULT) : 1;
    localparam logic [W-1:0] LAST = W'(MULT - 1);

    logic [W-1:0] pcnt;
    logic         tick_d;

    assign xfer_tick_o = tick_d && (pcnt == '0);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt   <= '0;
            tick_d <= 1'b0;
        end else begin
            tick_d <= fast_tick_i;
            if (fast_tick_i) begin
                pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fc_gate_seq.sv
module fc_gate_seq
    import fc_tb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic resync_i,
    input  logic period_tick_i,
    input  logic xfer_tick_i,
    output logic gate_o,
    output logic clear_o,
    output logic xfer_o
);
    seq_state_e state, state_nx;
    logic gate_nx, clear_nx, xfer_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_PRIME: if (period_tick_i) state_nx = SEQ_OPEN;
            SEQ_OPEN:  if (period_tick_i) state_nx = SEQ_SHUT;
            SEQ_SHUT:  if (period_tick_i) state_nx = SEQ_OPEN;
            default:   state_nx = SEQ_PRIME;
        endcase
        if (resync_i) begin
            state_nx = SEQ_PRIME;
        end
    end

    always_comb begin
        clear_nx = resync_i || (period_tick_i && (state != SEQ_OPEN));
        gate_nx  = (state == SEQ_OPEN) && !resync_i;
        xfer_nx  = xfer_tick_i && (state == SEQ_SHUT) && !clear_nx && !resync_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_PRIME;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_o  <= 1'b0;
            clear_o <= 1'b0;
            xfer_o  <= 1'b0;
        end else begin
            gate_o  <= gate_nx;
            clear_o <= clear_nx;
            xfer_o  <= xfer_nx;
        end
    end
endmodule

// File: rtl/fc_timebase_seq.sv
module fc_timebase_seq #(
    parameter int STAGE_DIV = 10,
    parameter int FAST_TAP  = 3,
    parameter int SLOW_TAP  = 6,
    parameter int XFER_MULT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic range_slow_i,
    output logic gate_o,
    output logic clear_o,
    output logic xfer_o
);
    localparam int CHAIN = SLOW_TAP;

    logic [CHAIN:0] carry;
    logic           range_q;
    logic           resync;
    logic           period_tick;
    logic           xfer_tick;

    always_ff @(posedge clk) begin
        range_q <= range_slow_i;
    end

    assign resync      = !rst && (range_slow_i != range_q);
    assign carry[0]    = 1'b1;
    assign period_tick = range_q ? carry[SLOW_TAP] : carry[FAST_TAP];

    for (genvar g = 0; g < CHAIN; g++) begin : g_stage
        fc_decade_stage #(.RATIO(STAGE_DIV)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .restart (resync),
            .step_i  (carry[g]),
            .wrap_o  (carry[g+1])
        );
    end

    fc_xfer_pacer #(.MULT(XFER_MULT)) u_pacer (
        .clk         (clk),
        .rst         (rst),
        .restart     (resync),
        .fast_tick_i (carry[FAST_TAP]),
        .xfer_tick_o (xfer_tick)
    );

    fc_gate_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .resync_i      (resync),
        .period_tick_i (period_tick),
        .xfer_tick_i   (xfer_tick),
        .gate_o        (gate_o),
        .clear_o       (clear_o),
        .xfer_o        (xfer_o)
    );
endmodule

// File: rtl/fc_timebase_seq_chk.sv
module fc_timebase_seq_chk (
    input logic clk,
    input logic rst,
    input logic range_slow_i,
    input logic gate_o,
    input logic clear_o,
    input logic xfer_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!gate_o && !clear_o && !xfer_o));

    assert_clear_gate_low_R4: assert property (@(posedge clk) disable iff (rst)
        clear_o |-> !gate_o);

    assert_clear_leads_gate_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_o) |-> $past(clear_o));

    assert_clear_single_R4: assert property (@(posedge clk) disable iff (rst)
        (clear_o && $stable(range_slow_i)) |=> !clear_o);

    assert_xfer_single_R5: assert property (@(posedge clk) disable iff (rst)
        xfer_o |=> !xfer_o);

    assert_xfer_vs_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !(xfer_o && clear_o));

    assert_xfer_vs_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !(xfer_o && gate_o));

    assert_range_restart_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(range_slow_i) |=> (clear_o && !gate_o && !xfer_o));
endmodule

bind fc_timebase_seq fc_timebase_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .range_slow_i (range_slow_i),
    .gate_o       (gate_o),
    .clear_o      (clear_o),
    .xfer_o       (xfer_o)
);

// File: tb/tb_fc_timebase_seq.sv
module tb_fc_timebase_seq;
    localparam int DIV   = 2;
    localparam int FAST  = 2;
    localparam int SLOW  = 5;
    localparam int MULT  = 4;
    localparam int TFAST = DIV ** FAST;
    localparam int TSLOW = DIV ** SLOW;
    localparam int XSTEP = MULT * TFAST;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rng = 1'b0;
    logic gate, clr, xfr;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #4 clk = ~clk;

    fc_timebase_seq #(
        .STAGE_DIV (DIV),
        .FAST_TAP  (FAST),
        .SLOW_TAP  (SLOW),
        .XFER_MULT (MULT)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .range_slow_i (rng),
        .gate_o       (gate),
        .clear_o      (clr),
        .xfer_o       (xfr)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    function automatic logic e_gate(int j, int t);
        return ((j / t) % 2) == 1;
    endfunction

    function automatic logic e_clear(int j, int t);
        return (((j + 1) % t) == 0) && ((((j + 1) / t) % 2) == 1);
    endfunction

    function automatic logic e_xfer(int j, int t);
        return ((j % XSTEP) == 0) && (j >= 2 * t) && (((j / t) % 2) == 0);
    endfunction

    // R1: reset holds all outputs low; released on a falling edge
    task automatic do_reset(input logic slow);
        @(negedge clk);
        rst = 1'b1;
        rng = slow;
        repeat (3) @(negedge clk);
        chk(gate, 1'b0, "R1", "gate in reset");
        chk(clr,  1'b0, "R1", "clear in reset");
        chk(xfr,  1'b0, "R1", "xfer in reset");
        rst = 1'b0;
    endtask

    // compares samples j = 0 .. n-1 of a timeline with period t
    task automatic run_line(input int t, input int n, input string gtag, input string xtag);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            chk(gate, e_gate(j, t),  gtag, $sformatf("gate j=%0d", j));
            chk(clr,  e_clear(j, t), "R4", $sformatf("clear j=%0d", j));
            chk(xfr,  e_xfer(j, t),  xtag, $sformatf("xfer j=%0d", j));
            chk(xfr && (gate || clr), 1'b0, "R6", $sformatf("overlap j=%0d", j));
        end
    endtask

    task automatic t_fast_run();
        do_reset(1'b0);
        run_line(TFAST, 100, "R2", "R7");
    endtask

    task automatic t_slow_run();
        int seen = 0;
        do_reset(1'b1);
        for (int j = 0; j < 100; j++) begin
            @(negedge clk);
            chk(gate, e_gate(j, TSLOW),  "R3", $sformatf("gate j=%0d", j));
            chk(clr,  e_clear(j, TSLOW), "R4", $sformatf("clear j=%0d", j));
            chk(xfr,  e_xfer(j, TSLOW),  "R8", $sformatf("xfer j=%0d", j));
            if (j >= 2 * TSLOW && j < 3 * TSLOW && xfr) seen++;
        end
        // R8: two transfers inside one shut half (j = 64 and 80)
        n_cmp++;
        if (seen != 2) begin
            n_bad++;
            $display("FAIL R8 xfers in shut half: got %0d expected 2", seen);
        end
    endtask

    // R5: spacing between surviving transfers in the fast range
    task automatic t_cadence();
        int last = -1;
        do_reset(1'b0);
        for (int j = 0; j < 80; j++) begin
            @(negedge clk);
            if (xfr) begin
                if (last >= 0) chk(1'b1, (j - last) == XSTEP, "R5", $sformatf("spacing %0d", j - last));
                else           chk(1'b1, j == XSTEP, "R5", $sformatf("first xfer j=%0d", j));
                last = j;
            end
        end
    endtask

    task automatic t_resync();
        do_reset(1'b0);
        run_line(TFAST, 10, "R2", "R7");
        rng = 1'b1;
        @(negedge clk);
        chk(clr,  1'b1, "R9", "forced clear to slow");
        chk(gate, 1'b0, "R9", "gate after change to slow");
        chk(xfr,  1'b0, "R9", "xfer after change to slow");
        run_line(TSLOW, 110, "R3", "R10");
        rng = 1'b0;
        @(negedge clk);
        chk(clr,  1'b1, "R9", "forced clear to fast");
        chk(gate, 1'b0, "R9", "gate cut when open window restarts");
        chk(xfr,  1'b0, "R9", "xfer after change to fast");
        run_line(TFAST, 40, "R2", "R10");
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            finish_up();
        end
    end

    initial begin
        t_fast_run();
        t_slow_run();
        t_cadence();
        t_resync();
        do_reset(1'b0);
        done = 1'b1;
        finish_up();
    end
endmodule